// File: doc/BRIEF.md
# TMDS Clock-Lane Pattern Generator

This block produces the 10-bit parallel character that a serializer shifts out on the TMDS clock lane. Four programmable 10-bit words are replayed in a fixed rotation, one word per character clock. With every word set to 0x01F (five ones, then five zeros) the lane carries a clock at one tenth of the bit rate. With words 0 and 1 at 0x000 and words 2 and 3 at 0x3FF, the lane carries a clock at one quarter of the character rate, which suits character rates above 340 MHz.

Software reaches the block through a small write port. Two 32-bit pattern registers each hold two words: one 16-bit half per word. A control register then moves the pattern through two steps. The value 1 takes a snapshot of both pattern registers into a load stage. The value 2 commits the load stage to the active pattern and restarts the rotation at word 0. Any number of character clocks may pass between the two steps, so the pattern can settle before the commit. Because the active pattern changes only on a commit, and changes as a whole, the serializer never sees a pattern that is partly old and partly new.

Top module: `tclk_pattern_gen`

## Requirements
- R1: While reset is asserted, and after reset until the first commit, every character on `char_o` is 0x01F.
- R2: The register selector `wr_sel` uses these codes: 0 selects the low pattern register, 1 selects the high pattern register and 2 selects the control register. In the low register, word 0 sits in bits [9:0] and word 1 sits in bits [25:16]. In the high register, word 2 sits in bits [9:0] and word 3 sits in bits [25:16].
- R3: Bits [15:10] and [31:26] of a pattern register write have no effect on any word that is emitted.
- R4: A control write of exactly 1 copies both pattern registers into the load stage and does not change `char_o`.
- R5: A control write of exactly 2 copies the load stage into the active pattern. In the cycle after that edge `char_o` shows active word 0, and it then shows words 1, 2 and 3 on the following edges.
- R6: Pattern writes never change `char_o` until a commit. Pattern writes made after a load and before the commit are not part of that commit.
- R7: A control write of any value other than 1 or 2, and any write with selector code 3, changes neither the load stage nor the active pattern.
- R8: A commit issued after reset with no load before it makes the default pattern (all words 0x01F) active.
- R9: With no commit, the output advances one word per clock and wraps from word 3 to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_sel | input | 2 | Register selector: 0 low pattern, 1 high pattern, 2 control |
| wr_data | input | 32 | Write data |
| char_o | output | 10 | Character toward the serializer |

## Verification
On every cycle the assertions check how the word index moves: it restarts at zero after a commit and otherwise steps by one and wraps. They also check that the active pattern stays frozen unless a commit occurs, that a commit copies the load stage exactly, and that ignored control values or selector 3 leave both stages untouched. Only the bench scenarios show the values the serializer actually sees. These include the field positions inside the pattern registers, the masking of the unused upper bits, the isolation of writes made between load and commit, the quarter-rate pattern, and the default pattern that a commit issued with no load produces.

// File: rtl/tclk_pat_pkg.sv
package tclk_pat_pkg;
  localparam int WORD_W    = 10;
  localparam int NUM_WORDS = 4;
  localparam int REG_W     = 32;
  localparam int SEL_W     = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PAT_LO = 2'd0,
    SEL_PAT_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam logic [REG_W-1:0]  CTRL_LOAD    = 32'd1;
  localparam logic [REG_W-1:0]  CTRL_COMMIT  = 32'd2;
  localparam logic [WORD_W-1:0] DEFAULT_WORD = 10'h01F;
endpackage

// File: rtl/tclk_pat_regs.sv
module tclk_pat_regs
  import tclk_pat_pkg::*;
#(
  parameter int W_W   = WORD_W,
  parameter int N_W   = NUM_WORDS,
  parameter int R_W   = REG_W,
  parameter logic [W_W-1:0] DEF_W = DEFAULT_WORD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic [R_W-1:0]       wr_data,
  output logic                 commit_o,
  output logic [N_W*W_W-1:0]   loaded_o,
  output logic [N_W*W_W-1:0]   active_o
);
  localparam int HALF_W  = R_W / 2;
  localparam int PER_REG = 2;
  localparam int FLAT_W  = N_W * W_W;

  logic [FLAT_W-1:0] staged_q, staged_d;
  logic [FLAT_W-1:0] loaded_q, loaded_d;
  logic [FLAT_W-1:0] active_q, active_d;
  logic              ctrl_hit, load_hit, commit_hit;

  assign ctrl_hit   = wr_en && (wr_sel == SEL_CTRL);
  assign load_hit   = ctrl_hit && (wr_data == CTRL_LOAD);
  assign commit_hit = ctrl_hit && (wr_data == CTRL_COMMIT);

  for (genvar w = 0; w < N_W; w++) begin : g_word
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(w / PER_REG);
    localparam int               LSB    = (w % PER_REG) * HALF_W;
    logic wr_hit;
    assign wr_hit = wr_en && (wr_sel == MY_SEL);
    always_comb begin
      staged_d[w*W_W +: W_W] = staged_q[w*W_W +: W_W];
      if (wr_hit) staged_d[w*W_W +: W_W] = wr_data[LSB +: W_W];
    end
  end

  always_comb begin
    loaded_d = loaded_q;
    active_d = active_q;
    if (load_hit)   loaded_d = staged_q;
    if (commit_hit) active_d = loaded_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= {N_W{DEF_W}};
      loaded_q <= {N_W{DEF_W}};
      active_q <= {N_W{DEF_W}};
    end else begin
      staged_q <= staged_d;
      loaded_q <= loaded_d;
      active_q <= active_d;
    end
  end

  assign commit_o = commit_hit;
  assign loaded_o = loaded_q;
  assign active_o = active_q;
endmodule

// File: rtl/tclk_pat_seq.sv
module tclk_pat_seq #(
  parameter int W_W = 10,
  parameter int N_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic [N_W*W_W-1:0]   active,
  output logic [$clog2(N_W)-1:0] idx_o,
  output logic [W_W-1:0]       char_o
);
  localparam int IDX_W = $clog2(N_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_W - 1);

  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    if (restart)            idx_d = '0;
    else if (idx_q == LAST) idx_d = '0;
    else                    idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o  = idx_q;
  assign char_o = active[idx_q*W_W +: W_W];
endmodule

// File: rtl/tclk_pattern_gen.sv
module tclk_pattern_gen
  import tclk_pat_pkg::*;
#(
  parameter int W_W = WORD_W,
  parameter int N_W = NUM_WORDS,
  parameter int R_W = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [R_W-1:0]   wr_data,
  output logic [W_W-1:0]   char_o
);
  localparam int IDX_W  = $clog2(N_W);
  localparam int FLAT_W = N_W * W_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              commit;
  logic [FLAT_W-1:0] loaded_flat;
  logic [FLAT_W-1:0] active_flat;
  logic [IDX_W-1:0]  cur_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tclk_pat_regs #(.W_W(W_W), .N_W(N_W), .R_W(R_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .commit_o (commit),
    .loaded_o (loaded_flat),
    .active_o (active_flat)
  );

  tclk_pat_seq #(.W_W(W_W), .N_W(N_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (commit),
    .active  (active_flat),
    .idx_o   (cur_idx),
    .char_o  (char_o)
  );
endmodule

// File: rtl/tclk_pattern_gen_chk.sv
module tclk_pattern_gen_chk #(
  parameter int W_W = 10,
  parameter int N_W = 4,
  parameter int R_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [1:0]             wr_sel,
  input logic [R_W-1:0]         wr_data,
  input logic [$clog2(N_W)-1:0] cur_idx,
  input logic [N_W*W_W-1:0]     loaded_flat,
  input logic [N_W*W_W-1:0]     active_flat
);
  logic is_commit, is_other;
  assign is_commit = wr_en && wr_sel == 2'd2 && wr_data == R_W'(2);
  assign is_other  = wr_en && ((wr_sel == 2'd2 && wr_data != R_W'(1) && wr_data != R_W'(2))
                               || wr_sel == 2'd3);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_commit |=> cur_idx == '0);

  p_commit_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_commit |=> active_flat == $past(loaded_flat));

  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_commit |=> int'(cur_idx) == (int'($past(cur_idx)) + 1) % N_W);

  p_hold_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_commit |=> $stable(active_flat));

  p_ignore_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_other |=> $stable(loaded_flat) && $stable(active_flat));
endmodule

bind tclk_pattern_gen tclk_pattern_gen_chk #(.W_W(W_W), .N_W(N_W), .R_W(R_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .cur_idx     (cur_idx),
  .loaded_flat (loaded_flat),
  .active_flat (active_flat)
);

// File: tb/test_tclk_pattern_gen.sv
module test_tclk_pattern_gen;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [9:0]  char_o;

  int checks = 0;
  int errors = 0;

  logic [9:0] stg [4];
  logic [9:0] ld  [4];
  logic [9:0] act [4];
  int         idx;

  logic [9:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_P/2) clk = ~clk;

  tclk_pattern_gen i_tclk_pattern_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .char_o(char_o)
  );

  task automatic chk(input logic [9:0] act_v, input logic [9:0] exp_v, input string tag);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: char_o=%h expected %h", tag, act_v, exp_v);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      stg[i] = 10'h01F; ld[i] = 10'h01F; act[i] = 10'h01F;
    end
    idx = 0;
  endtask

  // driver: applies one cycle of stimulus and pushes the expected character
  task automatic step(input logic en, input logic [1:0] sel, input logic [31:0] d,
                      input string tag);
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d;
    if (en && sel == 2'd2 && d == 32'd2) begin
      for (int i = 0; i < 4; i++) act[i] = ld[i];
      idx = 0;
    end else begin
      idx = (idx + 1) % 4;
    end
    if (en && sel == 2'd2 && d == 32'd1)
      for (int i = 0; i < 4; i++) ld[i] = stg[i];
    if (en && sel == 2'd0) begin stg[0] = d[9:0]; stg[1] = d[25:16]; end
    if (en && sel == 2'd1) begin stg[2] = d[9:0]; stg[3] = d[25:16]; end
    exp_q.push_back(act[idx]);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'h0, tag);
  endtask

  // monitor: compares away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) chk(char_o, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 32'h0;
    repeat (3) @(posedge clk);
    #5 chk(char_o, 10'h01F, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    idle(6, "R1 default before commit");

    // staged writes with junk in unused upper bits: output unchanged
    step(1'b1, 2'd0, {6'h3F, 10'h155, 6'h2A, 10'h2AA}, "R6 low write no effect");
    step(1'b1, 2'd1, {6'h15, 10'h0F0, 6'h3F, 10'h30C}, "R6 high write no effect");
    step(1'b1, 2'd2, 32'd1, "R4 load no output change");
    idle(3, "R4 settling");
    step(1'b1, 2'd0, 32'h0123_0321, "R6 write after load");
    step(1'b1, 2'd2, 32'd7, "R7 ctrl other value");
    step(1'b1, 2'd2, 32'd0, "R7 ctrl zero");
    step(1'b1, 2'd3, 32'd2, "R7 selector 3");
    step(1'b1, 2'd2, 32'd2, "R5 commit word0");
    idle(8, "R9 R3 R2 rotation");
    step(1'b1, 2'd2, 32'd2, "R5 recommit restart");
    idle(2, "R5 after restart");
    step(1'b1, 2'd2, 32'd2, "R5 restart mid rotation");
    idle(4, "R9 wrap");

    // quarter-rate pattern
    step(1'b1, 2'd0, 32'h0000_0000, "R6 quarter low");
    step(1'b1, 2'd1, 32'h03FF_03FF, "R6 quarter high");
    step(1'b1, 2'd2, 32'd1, "R4 quarter load");
    step(1'b1, 2'd2, 32'd2, "R5 quarter commit");
    idle(7, "R2 quarter rotation");
    step(1'b1, 2'd2, 32'd1, "R4 reload same");
    idle(3, "R4 no change");

    // reset then commit with no load
    idle(2, "R9 drain");
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b0;
    #5 chk(char_o, 10'h01F, "R1 async reset");
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(3, "R1 after reset");
    step(1'b1, 2'd0, 32'h0111_0222, "R8 staged only");
    step(1'b1, 2'd2, 32'd2, "R8 commit without load");
    idle(5, "R8 default pattern");

    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #6;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule